// File: doc/BRIEF.md
# CAN Mailbox Transmit-Request Manager

This block holds the transmit requests of a CAN controller's 32 mailboxes and decides which waiting mailbox goes to the protocol engine next. The host sets a request by writing 1 to the mailbox's bit. Only the block clears requests. It clears one when the frame is sent, when a cancel succeeds, or when a mailbox that must not retry fails on the bus. Each cleared request leaves a mark in one of two sticky status vectors. One is for frames sent; the other is for aborted requests. A mailbox-empty flag is raised each time any request drops.

The engine sees a registered pick: a valid bit and a mailbox number. It pulses a start to take that mailbox, and then reports one outcome: sent, lost arbitration or bus error. The pick is ordered in one of two ways, chosen by a host mode bit. With mode 0 the lowest identifier wins. With mode 1 the highest mailbox number wins. The pick is recomputed on the same clock edge as every change to the request set, so a retry after a lost arbitration still presents the best frame.

Top module: `can_txreq_mgr`

## Requirements
- R1: After reset every register reads 0, `sel_valid` is 0, `eng_busy` is 0 and `irq_empty` is 0.
- R2: A host write sets every request bit written as 1. Bits written as 0 are left unchanged. Request registers sit at address 0 (mailboxes 15..0 on bits 15..0) and address 1 (mailboxes 31..16). Bit 0 of address 0, mailbox 0, always reads 0.
- R3: A write of 1 to a mailbox whose `mb_is_rx` bit is high is ignored.
- R4: An `eng_ok` pulse during a transmission clears that mailbox's request and sets its bit in the sent register (addresses 2/3, same bit map).
- R5: A `cancel_req` bit for a pending mailbox that is not being sent clears the request and sets its bit in the abort register (addresses 4/5). A cancel for a mailbox with no request changes nothing.
- R6: An `eng_arb_lost` or `eng_err` pulse leaves the request pending, drops `eng_busy`, and presents the mailbox again.
- R7: On a failure of a mailbox whose `mb_no_retry` bit is high, the request is cleared and its abort bit is set.
- R8: A cancel of the mailbox under transmission is held. If the frame then fails, the request is cleared and the abort bit is set. If the frame succeeds, only the sent bit is set.
- R9: `irq_empty` (readable as bit 0 of address 7) rises on the edge after any request bit goes from 1 to 0.
- R10: With mode 0 (bit 0 of address 6), the pending mailbox with the lowest identifier is picked. On a tie in identifier, the higher mailbox number is picked.
- R11: With mode 1, the highest-numbered pending mailbox is picked.
- R12: `sel_valid`/`sel_mb` change on the same edge as the request set. `sel_valid` is 0 when no request is pending. `eng_start` is taken only when `sel_valid` is high and `eng_busy` is low.
- R13: The sent, abort and interrupt flags are cleared by writing 1 to them; a write of 0 leaves them unchanged. A hardware set in the same cycle as a host clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe, data on the next cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| mb_id | input | 928 | Identifier of each mailbox, 29 bits each, mailbox 0 in the low bits |
| mb_is_rx | input | 32 | Mailbox is set for reception |
| mb_no_retry | input | 32 | Mailbox must not be retried after a failure |
| cancel_req | input | 32 | Cancel pulse for each mailbox |
| eng_start | input | 1 | Engine takes the presented mailbox |
| eng_ok | input | 1 | Frame sent |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_err | input | 1 | Bus error on the frame |
| sel_valid | output | 1 | A mailbox is presented |
| sel_mb | output | 5 | Presented mailbox number |
| eng_busy | output | 1 | A frame is in flight |
| eng_mb | output | 5 | Mailbox in flight |
| irq_empty | output | 1 | Mailbox-empty interrupt flag |

## Verification
The assertions check on every cycle that mailbox 0 never holds a request and that the presented mailbox is always pending, with `sel_valid` matching the request set. They also check that in mailbox-number mode no pending mailbox lies above the pick, that every dropped request raises the interrupt, that every drop has an engine outcome or a cancel behind it, and that the in-flight number holds steady. The order among identifiers, the held cancel that decides between sent and aborted, the per-mailbox retry choice and the race between set and clear depend on stimulus sequences, so only the bench's scenarios show them.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  // register group, upper address bits
  typedef enum logic [1:0] {
    GRP_PEND = 2'd0,
    GRP_SENT = 2'd1,
    GRP_ABRT = 2'd2,
    GRP_MISC = 2'd3
  } reg_grp_e;
  // selection order
  localparam logic ORD_BY_ID   = 1'b0;
  localparam logic ORD_BY_SLOT = 1'b1;
endpackage

// File: rtl/can_txreq_flags.sv
// Set/clear flag vector, hardware set wins over clear.
module can_txreq_flags #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [N-1:0] q;
  always_comb nxt_o = (q & ~clr_i) | set_i;
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end
  assign q_o = q;
endmodule

// File: rtl/can_txreq_pick.sv
// Picks the next mailbox from the next-state request vector; registered result.
module can_txreq_pick #(
  parameter int NUM_MB = 32,
  parameter int ID_W   = 29,
  localparam int MB_W  = $clog2(NUM_MB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MB-1:0]      req_i,
  input  logic [NUM_MB*ID_W-1:0] id_i,
  input  logic                   order_i,
  output logic                   valid_o,
  output logic [MB_W-1:0]        mb_o
);
  import can_txreq_pkg::*;
  logic            found;
  logic [MB_W-1:0] best;
  logic [ID_W-1:0] best_id;

  always_comb begin
    found   = 1'b0;
    best    = '0;
    best_id = '0;
    for (int i = 1; i < NUM_MB; i++) begin
      if (req_i[i]) begin
        if (order_i == ORD_BY_SLOT) begin
          best = MB_W'(i);
        end else if (!found || id_i[i*ID_W +: ID_W] <= best_id) begin
          best    = MB_W'(i);
          best_id = id_i[i*ID_W +: ID_W];
        end
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      mb_o    <= '0;
    end else begin
      valid_o <= found;
      mb_o    <= best;
    end
  end
endmodule

// File: rtl/can_txreq_txctl.sv
// Tracks the frame in flight and turns outcomes and cancels into clear/ack events.
module can_txreq_txctl #(
  parameter int NUM_MB = 32,
  localparam int MB_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ok_i,
  input  logic              arb_i,
  input  logic              err_i,
  input  logic              sel_valid_i,
  input  logic [MB_W-1:0]   sel_mb_i,
  input  logic [NUM_MB-1:0] pend_i,
  input  logic [NUM_MB-1:0] no_retry_i,
  input  logic [NUM_MB-1:0] cancel_i,
  output logic              busy_o,
  output logic [MB_W-1:0]   mb_o,
  output logic [NUM_MB-1:0] sent_set_o,
  output logic [NUM_MB-1:0] abrt_set_o,
  output logic [NUM_MB-1:0] clr_o
);
  logic              busy_q, hold_q;
  logic [MB_W-1:0]   mb_q;
  logic [NUM_MB-1:0] fly_mask, cancel_now, fail_mask;
  logic              succ, fail, hold_eff, drop_fail, take;

  always_comb begin
    fly_mask   = busy_q ? (NUM_MB'(1) << mb_q) : '0;
    succ       = busy_q && ok_i;
    fail       = busy_q && !ok_i && (arb_i || err_i);
    hold_eff   = hold_q || (busy_q && cancel_i[mb_q]);
    drop_fail  = fail && (no_retry_i[mb_q] || hold_eff);
    fail_mask  = drop_fail ? fly_mask : '0;
    cancel_now = cancel_i & pend_i & ~fly_mask & ~NUM_MB'(1);
    sent_set_o = succ ? fly_mask : '0;
    abrt_set_o = cancel_now | fail_mask;
    clr_o      = sent_set_o | abrt_set_o;
    take       = !busy_q && start_i && sel_valid_i && !cancel_i[sel_mb_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      mb_q   <= '0;
    end else if (succ || fail) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (take) begin
      busy_q <= 1'b1;
      hold_q <= 1'b0;
      mb_q   <= sel_mb_i;
    end else if (busy_q && cancel_i[mb_q]) begin
      hold_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign mb_o   = mb_q;
endmodule

// File: rtl/can_txreq_hostif.sv
// Host register decode and registered read mux.
module can_txreq_hostif #(
  parameter int NUM_MB = 32,
  parameter int REG_W  = 16,
  localparam int NR    = NUM_MB / REG_W,
  localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NUM_MB-1:0] pend_i,
  input  logic [NUM_MB-1:0] sent_i,
  input  logic [NUM_MB-1:0] abrt_i,
  input  logic              order_i,
  input  logic              irq_i,
  output logic [NUM_MB-1:0] pend_wr_o,
  output logic [NUM_MB-1:0] sent_clr_o,
  output logic [NUM_MB-1:0] abrt_clr_o,
  output logic              order_wr_o,
  output logic              order_wd_o,
  output logic              irq_clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  import can_txreq_pkg::*;
  reg_grp_e         grp;
  logic [IDX_W-1:0] idx;
  assign grp = reg_grp_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx = addr_i[IDX_W-1:0];

  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic hit;
    assign hit = wr_i && (idx == IDX_W'(r));
    assign pend_wr_o [r*REG_W +: REG_W] = (hit && grp == GRP_PEND) ? wdata_i : '0;
    assign sent_clr_o[r*REG_W +: REG_W] = (hit && grp == GRP_SENT) ? wdata_i : '0;
    assign abrt_clr_o[r*REG_W +: REG_W] = (hit && grp == GRP_ABRT) ? wdata_i : '0;
  end

  assign order_wr_o = wr_i && grp == GRP_MISC && idx == IDX_W'(0);
  assign order_wd_o = wdata_i[0];
  assign irq_clr_o  = wr_i && grp == GRP_MISC && idx == IDX_W'(1) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      unique case (grp)
        GRP_PEND: rdata_o <= pend_i[idx*REG_W +: REG_W];
        GRP_SENT: rdata_o <= sent_i[idx*REG_W +: REG_W];
        GRP_ABRT: rdata_o <= abrt_i[idx*REG_W +: REG_W];
        default:  rdata_o <= (idx == IDX_W'(0)) ? REG_W'(order_i)
                           : (idx == IDX_W'(1)) ? REG_W'(irq_i) : '0;
      endcase
    end
  end
endmodule

// File: rtl/can_txreq_mgr.sv
module can_txreq_mgr #(
  parameter int NUM_MB = 32,
  parameter int ID_W   = 29,
  parameter int REG_W  = 16,
  localparam int MB_W  = $clog2(NUM_MB),
  localparam int NR    = NUM_MB / REG_W,
  localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  input  logic [NUM_MB*ID_W-1:0] mb_id,
  input  logic [NUM_MB-1:0]      mb_is_rx,
  input  logic [NUM_MB-1:0]      mb_no_retry,
  input  logic [NUM_MB-1:0]      cancel_req,
  input  logic                   eng_start,
  input  logic                   eng_ok,
  input  logic                   eng_arb_lost,
  input  logic                   eng_err,
  output logic                   sel_valid,
  output logic [MB_W-1:0]        sel_mb,
  output logic                   eng_busy,
  output logic [MB_W-1:0]        eng_mb,
  output logic                   irq_empty
);
  logic [NUM_MB-1:0] pend_q, pend_nxt, pend_set, pend_wr;
  logic [NUM_MB-1:0] hw_clr, sent_set, abrt_set, sent_clr, abrt_clr;
  logic [NUM_MB-1:0] sent_q, sent_nxt, abrt_q, abrt_nxt;
  logic              order_q, order_nxt, order_wr, order_wd, irq_clr, irq_rise;
  logic [0:0]        irq_q, irq_nxt;

  can_txreq_hostif #(.NUM_MB(NUM_MB), .REG_W(REG_W)) u_host (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend_q), .sent_i(sent_q), .abrt_i(abrt_q),
    .order_i(order_q), .irq_i(irq_q[0]), .pend_wr_o(pend_wr),
    .sent_clr_o(sent_clr), .abrt_clr_o(abrt_clr), .order_wr_o(order_wr),
    .order_wd_o(order_wd), .irq_clr_o(irq_clr), .rdata_o(bus_rdata)
  );

  // host may only set, never for mailbox 0 or a receive mailbox
  assign pend_set = pend_wr & ~mb_is_rx & ~NUM_MB'(1);

  can_txreq_flags #(.N(NUM_MB)) u_pend (
    .clk(clk), .rst(rst), .set_i(pend_set), .clr_i(hw_clr),
    .q_o(pend_q), .nxt_o(pend_nxt)
  );
  can_txreq_flags #(.N(NUM_MB)) u_sent (
    .clk(clk), .rst(rst), .set_i(sent_set), .clr_i(sent_clr),
    .q_o(sent_q), .nxt_o(sent_nxt)
  );
  can_txreq_flags #(.N(NUM_MB)) u_abrt (
    .clk(clk), .rst(rst), .set_i(abrt_set), .clr_i(abrt_clr),
    .q_o(abrt_q), .nxt_o(abrt_nxt)
  );

  assign irq_rise = |(pend_q & ~pend_nxt);
  can_txreq_flags #(.N(1)) u_irq (
    .clk(clk), .rst(rst), .set_i(irq_rise), .clr_i(irq_clr),
    .q_o(irq_q), .nxt_o(irq_nxt)
  );
  assign irq_empty = irq_q[0];

  assign order_nxt = order_wr ? order_wd : order_q;
  always_ff @(posedge clk) begin
    if (rst) order_q <= 1'b0;
    else     order_q <= order_nxt;
  end

  can_txreq_txctl #(.NUM_MB(NUM_MB)) u_tx (
    .clk(clk), .rst(rst), .start_i(eng_start), .ok_i(eng_ok),
    .arb_i(eng_arb_lost), .err_i(eng_err), .sel_valid_i(sel_valid),
    .sel_mb_i(sel_mb), .pend_i(pend_q), .no_retry_i(mb_no_retry),
    .cancel_i(cancel_req), .busy_o(eng_busy), .mb_o(eng_mb),
    .sent_set_o(sent_set), .abrt_set_o(abrt_set), .clr_o(hw_clr)
  );

  can_txreq_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst(rst), .req_i(pend_nxt), .id_i(mb_id), .order_i(order_nxt),
    .valid_o(sel_valid), .mb_o(sel_mb)
  );
endmodule

// File: rtl/can_txreq_mgr_chk.sv
module can_txreq_mgr_chk #(
  parameter int NUM_MB = 32,
  localparam int MB_W  = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_MB-1:0] pend_q,
  input logic              order_q,
  input logic [NUM_MB-1:0] cancel_req,
  input logic              sel_valid,
  input logic [MB_W-1:0]   sel_mb,
  input logic              eng_busy,
  input logic [MB_W-1:0]   eng_mb,
  input logic              irq_empty
);
  a_r2_slot0_never_set: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0]);

  a_r12_valid_tracks_set: assert property (@(posedge clk) disable iff (rst)
    sel_valid == (|pend_q));

  a_r12_pick_is_pending: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> pend_q[sel_mb]);

  a_r11_none_above_pick: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && order_q) |-> ((pend_q >> sel_mb) == NUM_MB'(1)));

  a_r9_drop_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> irq_empty);

  a_r4_drop_has_cause: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> ($past(eng_busy) || $past(|cancel_req)));

  a_r8_flight_slot_stable: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && $past(eng_busy)) |-> $stable(eng_mb));
endmodule

bind can_txreq_mgr can_txreq_mgr_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst(rst), .pend_q(pend_q), .order_q(order_q),
  .cancel_req(cancel_req), .sel_valid(sel_valid), .sel_mb(sel_mb),
  .eng_busy(eng_busy), .eng_mb(eng_mb), .irq_empty(irq_empty)
);

// File: tb/can_txreq_mgr_tb.sv
module can_txreq_mgr_tb;
  localparam int NMB = 32;
  localparam int IDW = 29;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [NMB*IDW-1:0] mb_id;
  logic [NMB-1:0] mb_is_rx = '0, mb_no_retry = '0, cancel_req = '0;
  logic eng_start = 0, eng_ok = 0, eng_arb_lost = 0, eng_err = 0;
  logic sel_valid, eng_busy, irq_empty;
  logic [4:0] sel_mb, eng_mb;
  logic [IDW-1:0] ids [NMB];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < NMB; i++) begin : g_id
    assign mb_id[i*IDW +: IDW] = ids[i];
  end

  can_txreq_mgr u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mb_id(mb_id),
    .mb_is_rx(mb_is_rx), .mb_no_retry(mb_no_retry), .cancel_req(cancel_req),
    .eng_start(eng_start), .eng_ok(eng_ok), .eng_arb_lost(eng_arb_lost),
    .eng_err(eng_err), .sel_valid(sel_valid), .sel_mb(sel_mb),
    .eng_busy(eng_busy), .eng_mb(eng_mb), .irq_empty(irq_empty)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [15:0] exp, string req);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(req, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic pulse_start();
    @(negedge clk); eng_start = 1;
    @(negedge clk); eng_start = 0;
  endtask

  task automatic pulse_outcome(int kind);
    @(negedge clk);
    eng_ok = (kind == 0); eng_arb_lost = (kind == 1); eng_err = (kind == 2);
    @(negedge clk); eng_ok = 0; eng_arb_lost = 0; eng_err = 0;
  endtask

  task automatic pulse_cancel(int mb);
    @(negedge clk); cancel_req[mb] = 1'b1;
    @(negedge clk); cancel_req = '0;
  endtask

  task automatic clear_flags();
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF); wr(3'd7, 16'h0001);
  endtask

  task automatic t_reset();
    check("R1 sel_valid", 32'(sel_valid), 0);
    check("R1 busy", 32'(eng_busy), 0);
    check("R1 irq", 32'(irq_empty), 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0, "R1 register");
  endtask

  task automatic t_set_and_slot_order();
    wr(3'd6, 16'h0001);                 // mailbox-number order
    wr(3'd1, 16'h0001);                 // mb16
    wr(3'd0, 16'h0005);                 // mb0 ignored, mb2 set
    rd_chk(3'd0, 16'h0004, "R2 slot0 reads 0");
    wr(3'd0, 16'h0000);
    rd_chk(3'd0, 16'h0004, "R2 zero write keeps");
    check("R11 highest slot", 32'(sel_mb), 16);
    mb_is_rx[5] = 1'b1;
    wr(3'd0, 16'h0020);
    rd_chk(3'd0, 16'h0004, "R3 rx ignored");
    mb_is_rx = '0;
  endtask

  task automatic t_id_order();
    wr(3'd6, 16'h0000);
    check("R12 pick follows mode", 32'(sel_mb), 2);
    ids[16] = 29'd5;
    @(negedge clk);
    check("R10 id tie higher slot", 32'(sel_mb), 16);
  endtask

  task automatic t_success();
    pulse_start();
    check("R12 start taken", 32'(eng_busy), 1);
    check("R12 flight slot", 32'(eng_mb), 16);
    pulse_outcome(0);
    check("R9 irq on drop", 32'(irq_empty), 1);
    check("R12 next pick", 32'(sel_mb), 2);
    rd_chk(3'd1, 16'h0000, "R4 request cleared");
    rd_chk(3'd3, 16'h0001, "R4 sent bit");
  endtask

  task automatic t_retry();
    clear_flags();
    pulse_start();
    check("R6 flight slot", 32'(eng_mb), 2);
    pulse_outcome(1);
    check("R6 busy drops", 32'(eng_busy), 0);
    check("R6 re-presented", 32'({sel_valid, sel_mb}), 32'h22);
    check("R6 no irq", 32'(irq_empty), 0);
    pulse_start();
    pulse_outcome(2);
    rd_chk(3'd0, 16'h0004, "R6 still pending");
    rd_chk(3'd4, 16'h0000, "R6 no abort");
  endtask

  task automatic t_no_retry();
    mb_no_retry[2] = 1'b1;
    pulse_start();
    pulse_outcome(2);
    check("R12 none pending", 32'(sel_valid), 0);
    rd_chk(3'd0, 16'h0000, "R7 cleared");
    rd_chk(3'd4, 16'h0004, "R7 abort bit");
    mb_no_retry = '0;
    clear_flags();
    rd_chk(3'd4, 16'h0000, "R13 abort w1c");
    check("R13 irq w1c", 32'(irq_empty), 0);
  endtask

  task automatic t_cancel();
    wr(3'd0, 16'h0008);
    pulse_cancel(3);
    rd_chk(3'd0, 16'h0000, "R5 cancel clears");
    rd_chk(3'd4, 16'h0008, "R5 abort bit");
    pulse_cancel(4);
    rd_chk(3'd4, 16'h0008, "R5 idle cancel no effect");
    clear_flags();
  endtask

  task automatic t_cancel_in_flight();
    wr(3'd0, 16'h0040);
    pulse_start();
    pulse_cancel(6);
    rd_chk(3'd0, 16'h0040, "R8 held while sending");
    pulse_outcome(0);
    rd_chk(3'd2, 16'h0040, "R8 success acks");
    rd_chk(3'd4, 16'h0000, "R8 success no abort");
    wr(3'd0, 16'h0080);
    pulse_start();
    pulse_cancel(7);
    pulse_outcome(1);
    rd_chk(3'd0, 16'h0000, "R8 fail clears");
    rd_chk(3'd4, 16'h0080, "R8 fail aborts");
    clear_flags();
  endtask

  task automatic t_set_wins();
    wr(3'd0, 16'h0100);
    @(negedge clk);
    cancel_req[8] = 1'b1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = 16'h0100;
    @(negedge clk);
    cancel_req = '0; bus_wr = 0;
    rd_chk(3'd4, 16'h0100, "R13 set beats clear");
    wr(3'd4, 16'h0000);
    rd_chk(3'd4, 16'h0100, "R13 zero keeps");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NMB; i++) ids[i] = IDW'(200 + i);
    ids[2] = 29'd5;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_set_and_slot_order();
    t_id_order();
    t_success();
    t_retry();
    t_no_retry();
    t_cancel();
    t_cancel_in_flight();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule